// File: doc/BRIEF.md
# Multichannel Equivalent-Time Acquisition Sequencer

This block sequences an equivalent-time waveform capture for a group of probe front-ends that share one acquisition kernel. Three nested counting loops run inside it. The innermost loop issues a fixed number of comparator decisions at one reference level. The middle loop sweeps the reference-voltage code through all of its values. The outer loop steps the sample-delay code. Each time the delay sweep wraps, the coarse sample position moves one system-clock cycle later. Capture ends after a programmed number of coarse cycles.

The block drives the reference and delay codes, an increment strobe for each code, a per-cycle sampling enable and a coarse-advance strobe. It also issues a tag at the end of each reference sweep, so that a downstream digitizer can place its result in time. A channel register, loaded at start, powers exactly one front-end while a capture runs and keeps every other front-end off. The analog delay line, the DAC and the digitizing math are outside this block.

A start pulse loads the channel and the loop count, but only when no capture is running. A synchronous abort returns the block to idle at once.

Top module: `wfa_acq_seq`

## Requirements
- R1: After reset the block is idle. busy, done, sample_en, ref_inc, dly_inc, coarse_adv and tag_valid are 0, and ref_code, dly_code, cyc_idx and ch_en are all zero.
- R2: While busy, sample_en is 1 on every cycle. ref_inc is 1 on each cycle that completes a group of 2^CMP_W comparisons, and ref_code is one higher (modulo 2^REF_W) on the following cycle.
- R3: dly_inc is 1 when a comparison group completes while ref_code is at its maximum. On the next cycle ref_code is 0 and dly_code is one higher (modulo 2^DLY_W).
- R4: coarse_adv is 1 when dly_inc occurs while dly_code is at its maximum. On the next cycle both codes are 0 and cyc_idx is one higher.
- R5: After loop_count coarse cycles, busy falls and done rises on the cycle after the last coarse_adv, with cyc_idx equal to loop_count and both codes 0. done then holds until the next accepted start or an abort.
- R6: While busy, ch_en has exactly one bit set, at the index of the latched channel (bit i powers channel i). While not busy, ch_en is all zeros.
- R7: start is accepted only while not busy. It latches ch_sel and loop_count and clears done. A start or a change of ch_sel or loop_count during a run has no effect on the outputs.
- R8: tag_valid is 1 on exactly the cycles where dly_inc is 1. On those cycles tag_cyc equals cyc_idx and tag_dly equals dly_code.
- R9: abort takes priority over start. On the next cycle the block is idle, with busy, done and ch_en at 0 and ref_code, dly_code and cyc_idx at 0.
- R10: An accepted start with loop_count equal to 0 sets done on the next cycle. busy stays 0, and no strobe and no channel enable is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when not busy |
| abort | input | 1 | Synchronous return to idle |
| ch_sel | input | ch_bits(NUM_CH) | Channel to capture |
| loop_count | input | CYC_W | Number of coarse cycles to capture |
| ref_code | output | REF_W | Reference-voltage code |
| dly_code | output | DLY_W | Sample-delay code |
| cyc_idx | output | CYC_W | Coarse cycle index |
| sample_en | output | 1 | A comparison is issued this cycle |
| ref_inc | output | 1 | Reference code steps after this cycle |
| dly_inc | output | 1 | Delay code steps after this cycle |
| coarse_adv | output | 1 | Coarse position advances after this cycle |
| ch_en | output | NUM_CH | One-hot front-end power enable |
| tag_valid | output | 1 | Reference sweep complete at this point |
| tag_cyc | output | CYC_W | Coarse index of the tagged point |
| tag_dly | output | DLY_W | Delay code of the tagged point |
| busy | output | 1 | Capture running |
| done | output | 1 | Capture finished |

## Verification
Two events can land in the same cycle and need care. The first is the final coarse advance together with loop termination: the cycle that wraps the delay sweep for the last time must also end the run, and cyc_idx must stop at loop_count. The second is abort together with start, where abort must win. The bench shortens every loop through its parameters so that full runs of one, two and the largest count reach termination. It pulses abort and start on the same edge in the middle of a sweep. A behavioural model derives every expected output from a running comparison count and is checked against the design on each clock.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    // Width of a channel index; at least one bit.
    function automatic int ch_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wfa_step_ctr.sv
module wfa_step_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q,
    output logic         at_max
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (en)
            q <= q + 1'b1;
    end

    assign at_max = (q == MAXV);

endmodule

// File: rtl/wfa_chan_gate.sv
module wfa_chan_gate #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic              on,
    input  logic [CH_W-1:0]   sel,
    output logic [NUM_CH-1:0] pwr
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        assign pwr[g] = on && (sel == CH_W'(g));
    end
endmodule

// File: rtl/wfa_acq_seq.sv
module wfa_acq_seq
    import wfa_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int REF_W  = 10,
    parameter int DLY_W  = 10,
    parameter int CMP_W  = 10,
    parameter int CYC_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        abort,
    input  logic [ch_bits(NUM_CH)-1:0]  ch_sel,
    input  logic [CYC_W-1:0]            loop_count,
    output logic [REF_W-1:0]            ref_code,
    output logic [DLY_W-1:0]            dly_code,
    output logic [CYC_W-1:0]            cyc_idx,
    output logic                        sample_en,
    output logic                        ref_inc,
    output logic                        dly_inc,
    output logic                        coarse_adv,
    output logic [NUM_CH-1:0]           ch_en,
    output logic                        tag_valid,
    output logic [CYC_W-1:0]            tag_cyc,
    output logic [DLY_W-1:0]            tag_dly,
    output logic                        busy,
    output logic                        done
);
    localparam int CH_W = ch_bits(NUM_CH);

    seq_state_e       state_q;
    logic [CH_W-1:0]  ch_q;
    logic [CYC_W-1:0] limit_q;
    logic [CMP_W-1:0] cmp_q;
    logic             cmp_last, ref_last, dly_last;
    logic             accept, clr_loops, last_coarse;

    assign busy   = (state_q == SEQ_RUN);
    assign done   = (state_q == SEQ_FIN);
    assign accept = start && !abort && !busy;
    assign clr_loops = abort || accept;

    // Strobe chain: each level carries into the next.
    assign sample_en  = busy;
    assign ref_inc    = busy && cmp_last;
    assign dly_inc    = ref_inc && ref_last;
    assign coarse_adv = dly_inc && dly_last;
    assign last_coarse = coarse_adv &&
        (({1'b0, cyc_idx} + (CYC_W+1)'(1)) == {1'b0, limit_q});

    assign tag_valid = dly_inc;
    assign tag_cyc   = cyc_idx;
    assign tag_dly   = dly_code;

    wfa_step_ctr #(.W(CMP_W)) i_cmp_ctr (
        .clk(clk), .rst(rst), .clr(clr_loops), .en(sample_en),
        .q(cmp_q), .at_max(cmp_last)
    );
    wfa_step_ctr #(.W(REF_W)) i_ref_ctr (
        .clk(clk), .rst(rst), .clr(clr_loops), .en(ref_inc),
        .q(ref_code), .at_max(ref_last)
    );
    wfa_step_ctr #(.W(DLY_W)) i_dly_ctr (
        .clk(clk), .rst(rst), .clr(clr_loops), .en(dly_inc),
        .q(dly_code), .at_max(dly_last)
    );

    always_ff @(posedge clk) begin
        if (rst || clr_loops)
            cyc_idx <= '0;
        else if (coarse_adv)
            cyc_idx <= cyc_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            ch_q    <= '0;
            limit_q <= '0;
        end else if (abort) begin
            state_q <= SEQ_IDLE;
        end else if (accept) begin
            ch_q    <= ch_sel;
            limit_q <= loop_count;
            state_q <= (loop_count == '0) ? SEQ_FIN : SEQ_RUN;
        end else if (busy && last_coarse) begin
            state_q <= SEQ_FIN;
        end
    end

    wfa_chan_gate #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_gate (
        .on(busy), .sel(ch_q), .pwr(ch_en)
    );

    // R2: reference code steps after its strobe
    a_r2_ref_step: assert property (@(posedge clk) disable iff (rst)
        (ref_inc && !abort) |=> ref_code == REF_W'($past(ref_code) + 1'b1));

    // R4: delay wrap clears both codes
    a_r4_wrap_clear: assert property (@(posedge clk) disable iff (rst)
        (coarse_adv && !abort) |=> (ref_code == '0 && dly_code == '0));

    // R5: done holds until start or abort
    a_r5_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start && !abort) |=> done);

    // R6: one front-end powered while running, none otherwise
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        busy |-> $countones(ch_en) == 1);
    a_r6_all_off: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ch_en == '0);

    // R7: channel stays fixed across a run
    a_r7_ch_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ch_en));

    // R9: abort returns to idle with codes cleared
    a_r9_abort: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !done && ch_en == '0 &&
                   ref_code == '0 && dly_code == '0 && cyc_idx == '0));

    // R10: zero count finishes at once
    a_r10_zero: assert property (@(posedge clk) disable iff (rst)
        (start && !abort && !busy && loop_count == '0) |=> (done && !busy));

endmodule

// File: tb/test_wfa_acq_seq.sv
module test_wfa_acq_seq;
    localparam int NCH = 8, RW = 2, DW = 2, CW = 2, YW = 3;
    localparam int C = 1 << CW, R = 1 << RW, D = 1 << DW, P = C * R * D;

    logic clk = 0, rst = 1, start = 0, abort = 0;
    logic [2:0] ch_sel = 0;
    logic [YW-1:0] loop_count = 0;
    logic [RW-1:0] ref_code;
    logic [DW-1:0] dly_code, tag_dly;
    logic [YW-1:0] cyc_idx, tag_cyc;
    logic sample_en, ref_inc, dly_inc, coarse_adv, tag_valid, busy, done;
    logic [NCH-1:0] ch_en;

    always #5 clk = ~clk;

    wfa_acq_seq #(.NUM_CH(NCH), .REF_W(RW), .DLY_W(DW), .CMP_W(CW), .CYC_W(YW)) i_wfa_acq_seq (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .ch_sel(ch_sel),
        .loop_count(loop_count), .ref_code(ref_code), .dly_code(dly_code),
        .cyc_idx(cyc_idx), .sample_en(sample_en), .ref_inc(ref_inc),
        .dly_inc(dly_inc), .coarse_adv(coarse_adv), .ch_en(ch_en),
        .tag_valid(tag_valid), .tag_cyc(tag_cyc), .tag_dly(tag_dly),
        .busy(busy), .done(done));

    int n_chk = 0, n_bad = 0;
    int m_run = 0, m_done = 0, m_n = 0, m_loop = 0, m_ch = 0, m_hold = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_run = 0; m_done = 0; m_n = 0; m_hold = 0;
        end else if (abort) begin
            m_run = 0; m_done = 0; m_n = 0; m_hold = 0;
        end else if (m_run != 0) begin
            if (m_n + 1 == m_loop * P) begin
                m_run = 0; m_done = 1; m_hold = m_loop;
            end else m_n++;
        end else if (start) begin
            m_ch = int'(ch_sel); m_loop = int'(loop_count); m_done = 0; m_hold = 0;
            if (m_loop == 0) m_done = 1;
            else begin m_run = 1; m_n = 0; end
        end
    endtask

    task automatic compare_all();
        int e_cmp, e_ref, e_dly, e_cyc, e_ch;
        bit e_ri, e_di, e_ca;
        if (m_run != 0) begin
            e_cmp = m_n % C; e_ref = (m_n / C) % R; e_dly = (m_n / (C * R)) % D;
            e_cyc = m_n / P; e_ch = 1 << m_ch;
            e_ri = (e_cmp == C - 1); e_di = e_ri && (e_ref == R - 1); e_ca = e_di && (e_dly == D - 1);
        end else begin
            e_ref = 0; e_dly = 0; e_cyc = m_hold; e_ch = 0; e_ri = 0; e_di = 0; e_ca = 0;
        end
        chk(sample_en == (m_run != 0), "R2 sample_en", int'(sample_en), m_run);
        chk(ref_inc == e_ri, "R2 ref_inc", int'(ref_inc), int'(e_ri));
        chk(int'(ref_code) == e_ref, "R2 ref_code", int'(ref_code), e_ref);
        chk(dly_inc == e_di, "R3 dly_inc", int'(dly_inc), int'(e_di));
        chk(int'(dly_code) == e_dly, "R3 dly_code", int'(dly_code), e_dly);
        chk(coarse_adv == e_ca, "R4 coarse_adv", int'(coarse_adv), int'(e_ca));
        chk(int'(cyc_idx) == e_cyc, "R4 cyc_idx", int'(cyc_idx), e_cyc);
        chk(busy == (m_run != 0), "R5 busy", int'(busy), m_run);
        chk(done == (m_done != 0), "R5 done", int'(done), m_done);
        chk(int'(ch_en) == e_ch, "R6 ch_en", int'(ch_en), e_ch);
        chk(tag_valid == e_di, "R8 tag_valid", int'(tag_valid), int'(e_di));
        if (e_di) begin
            chk(int'(tag_cyc) == e_cyc, "R8 tag_cyc", int'(tag_cyc), e_cyc);
            chk(int'(tag_dly) == e_dly, "R8 tag_dly", int'(tag_dly), e_dly);
        end
    endtask

    task automatic step();
        @(posedge clk); model_edge();
        @(negedge clk); compare_all();
    endtask

    task automatic go(input int ch, input int cnt);
        ch_sel = 3'(ch); loop_count = YW'(cnt); start = 1; step(); start = 0;
    endtask

    task automatic run_to_done();
        for (int k = 0; k < 8 * P && !done; k++) step();
    endtask

    task automatic main_seq();
        @(negedge clk);
        repeat (3) step();
        rst = 0; step();
        // R1: idle after reset
        chk(!busy && !done && ch_en == 0 && ref_code == 0 && dly_code == 0,
            "R1 idle after reset", int'({busy, done}), 0);
        // Run of two coarse cycles with start and channel change mid-run (R7)
        go(2, 2);
        repeat (30) step();
        ch_sel = 3'd5; loop_count = 3'd6; start = 1; step(); start = 0;
        step();
        chk(ch_en == 8'b0000_0100, "R7 channel unchanged", int'(ch_en), 4);
        run_to_done();
        chk(done && cyc_idx == 3'd2, "R5 finished at count", int'(cyc_idx), 2);
        repeat (5) step();
        chk(done && !busy, "R5 done held", int'(done), 1);
        // Single coarse cycle on top channel
        go(7, 1);
        run_to_done();
        chk(done && cyc_idx == 3'd1, "R5 single cycle", int'(cyc_idx), 1);
        // Abort mid-sweep together with start (R9)
        go(0, 3);
        repeat (100) step();
        abort = 1; start = 1; ch_sel = 3'd3; step(); abort = 0; start = 0;
        chk(!busy && !done && ch_en == 0 && ref_code == 0 && dly_code == 0 && cyc_idx == 0,
            "R9 abort idle", int'({busy, done}), 0);
        repeat (3) step();
        // Zero count (R10)
        go(6, 0);
        chk(done && !busy && ch_en == 0 && !sample_en, "R10 zero count done", int'(done), 1);
        repeat (3) step();
        chk(done && !ref_inc && !dly_inc, "R10 no strobes", int'(ref_inc), 0);
        // Largest count
        go(4, 7);
        run_to_done();
        chk(done && cyc_idx == 3'd7, "R5 max count", int'(cyc_idx), 7);
        repeat (2) step();
    endtask

    initial begin
        bit wd = 0;
        fork
            main_seq();
            begin repeat (20000) @(posedge clk); wd = 1; end
        join_any
        disable fork;
        if (wd) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule